// File: doc/BRIEF.md
# HDLC Transmit FIFO Controller

This block buffers the bytes of outgoing HDLC frames for one channel and turns them into a bit-serial line stream. A host writes one byte per cycle together with a 2-bit function code. One code value marks the byte as the last of its frame, so frame boundaries are carried through the FIFO with the data. Several complete frames can be queued at once. The transmit stage sends continuous flags while idle. It opens each frame with a flag, inserts a zero after five consecutive ones, appends a 16-bit frame check sequence and closes with a flag.

The host reads how many more bytes the FIFO can take. It receives three sticky interrupt bits, each cleared by writing one to it: occupancy below a programmable threshold, frame transmitted, and underrun. An underrun happens when the FIFO runs dry in the middle of a frame. The transmitter then sends an abort of eight ones, returns to flags and throws away the rest of that frame up to its end marker. Writes to a full FIFO are dropped without notice. A local loopback mode hands every transmitted payload byte to a receive-FIFO write port instead of the line, and holds the line at ones.

Top module: `htx_fifo_ctrl`

## Requirements
- R1: An accepted write stores 8 data bits and a 2-bit function code. Code 2'b01 marks the last byte of a frame, and codes 2'b00, 2'b10 and 2'b11 mark ordinary data bytes. Bytes are sent in write order.
- R2: Two or more complete frames written back to back before transmission starts are sent as separate frames, in write order.
- R3: `free_cnt` equals DEPTH minus the number of stored bytes and is updated on the clock edge that stores or removes a byte.
- R4: A write while the FIFO holds DEPTH bytes is discarded. It sets no interrupt bit, and the byte is missing from the transmitted frame.
- R5: `irq_status[0]` is set on each edge where the occupancy is below `thresh`. It stays set until cleared, and it clears only when the occupancy is at or above `thresh`.
- R6: `irq_status[1]` is set once for each frame whose final FCS bit has been sent.
- R7: If the FIFO is empty when a non-final byte of a frame completes, `irq_status[2]` is set and the line carries eight ones. Flags then resume, and every byte up to and including the next end-marked byte is discarded without being sent. No frame-done bit is raised for the aborted frame.
- R8: While no frame is pending, the line carries the flag 0x7E without a break, least significant bit first.
- R9: A frame on the line is an opening flag, then the payload bits LSB first, then the FCS, then a closing flag. The FCS is CRC-16 with reflected polynomial 0x8408 and all-ones preset, complemented and sent low byte first. A zero is inserted after every five consecutive ones from the first payload bit to the last FCS bit.
- R10: With `loop_en` high, each transmitted payload byte appears on `rx_data` with a one-cycle `rx_wr_en` pulse, and `rx_last` is high for the end-marked byte. `tx_bit` stays 1 while `loop_en` is high. `rx_wr_en` stays 0 while `loop_en` is low.
- R11: While reset is asserted, `free_cnt` equals DEPTH, `irq_status` is 0, `tx_bit` is 1 and `rx_wr_en` is 0.
- R12: An interrupt bit stays set until a 1 is written to its position of `irq_clr`. When a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_func | input | 2 | Function code, 2'b01 = last byte of frame |
| free_cnt | output | $clog2(DEPTH+1) | Bytes that can still be written |
| thresh | input | $clog2(DEPTH+1) | Low-occupancy threshold |
| irq_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| irq_status | output | 3 | {underrun, frame done, below threshold} |
| bit_tick | input | 1 | Line bit enable, one bit per cycle when high |
| loop_en | input | 1 | Local loopback select |
| tx_bit | output | 1 | Serial line output |
| rx_wr_en | output | 1 | Loopback receive write strobe |
| rx_data | output | 8 | Loopback received byte |
| rx_last | output | 1 | Loopback byte ends a frame |

## Verification
On every cycle the assertions check the following. The FIFO level never passes its depth. A write into a full FIFO leaves the level unchanged. The zero-insertion counter never lets six ones through inside a frame. A frame-done pulse never lasts two cycles. Interrupt bits never drop without a clear. The transmitter never enters a frame while the remains of an aborted frame are being discarded. Only the bench's scenarios show the line-level behaviour. A bit-level decoder in the bench recovers frame contents and FCS from the serial stream, counts aborts and checks the idle flag pattern. The bench also covers multi-frame queuing, the missing byte after an overflow, the discard after an underrun, and loopback delivery.

// File: rtl/htx_pkg.sv
// Package htx_pkg: shared types and constants of the HDLC transmit FIFO controller.
// Assumes LSB-first bit order on the line and the reflected CRC-16 used by HDLC.
package htx_pkg;
    localparam logic [1:0]  FUNC_LAST = 2'b01;
    localparam logic [7:0]  FLAG_PAT  = 8'h7E;
    localparam logic [15:0] CRC_POLY  = 16'h8408;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;

    typedef enum logic [1:0] {ST_FLAG, ST_DATA, ST_FCS, ST_ABORT} ser_st_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } fifo_ent_t;

    // One bit of the reflected CRC-16 update.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[15:1]} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction
endpackage

// File: rtl/htx_byte_fifo.sv
// Module htx_byte_fifo: circular byte store with an end-of-frame flag per entry.
// Pushes into a full store are dropped. The head entry is read combinationally.
module htx_byte_fifo
    import htx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  fifo_ent_t     push_ent,
    input  logic          pop,
    output fifo_ent_t     head,
    output logic          empty,
    output logic [CW-1:0] level
);
    fifo_ent_t mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic full, do_push, do_pop;

    // Accept and remove qualifiers.
    always_comb begin
        full    = (level == CW'(DEPTH));
        empty   = (level == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rp];
    end

    // Entry storage, written on accepted pushes only.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_ent;
    end

    // Pointer and level bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == CW'(DEPTH))); // R4
endmodule

// File: rtl/htx_serializer.sv
// Module htx_serializer: HDLC bit engine. Sends idle flags and frames with zero
// insertion and FCS, aborts on underrun and discards the rest of an aborted frame.
// Assumes bit_en paces the line and the byte source is the FIFO head.
module htx_serializer
    import htx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  fifo_ent_t  head,
    input  logic       empty,
    output logic       pop,
    output logic       line,
    output logic       done_p,
    output logic       und_p,
    output logic       rx_v,
    output logic [7:0] rx_d,
    output logic       rx_l
);
    ser_st_e     st;
    logic [2:0]  idx, ones, ones_nx;
    logic [7:0]  sh, byte_q, fcs2;
    logic [15:0] crc, crc_nx;
    logic        cur_last, fcs_second, pend, discard;
    logic        stuff_now, cur_bit, byte_end;
    logic        load_first, load_next, drop_pop;

    // Next-bit values and the byte fetch decisions.
    always_comb begin
        stuff_now  = (ones == 3'd5);
        cur_bit    = sh[0];
        crc_nx     = crc_step(crc, cur_bit);
        ones_nx    = cur_bit ? ones + 3'd1 : 3'd0;
        byte_end   = (idx == 3'd7);
        load_first = bit_en && st == ST_FLAG && !pend && byte_end && !empty && !discard;
        load_next  = bit_en && st == ST_DATA && !stuff_now && byte_end && !cur_last && !empty;
        drop_pop   = discard && !empty;
        pop        = load_first || load_next || drop_pop;
    end

    // Line state machine, one step per enabled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_FLAG; idx <= '0; ones <= '0; sh <= '0; byte_q <= '0;
            fcs2 <= '0; crc <= CRC_INIT; cur_last <= 1'b0; fcs_second <= 1'b0;
            pend <= 1'b0; discard <= 1'b0; line <= 1'b1; done_p <= 1'b0;
            und_p <= 1'b0; rx_v <= 1'b0; rx_d <= '0; rx_l <= 1'b0;
        end else begin
            done_p <= 1'b0;
            und_p  <= 1'b0;
            rx_v   <= 1'b0;
            if (drop_pop && head.last) discard <= 1'b0;
            if (bit_en) begin
                case (st)
                    ST_FLAG: begin
                        if (pend) begin
                            line <= 1'b0;
                            pend <= 1'b0;
                        end else begin
                            line <= FLAG_PAT[idx];
                            idx  <= idx + 3'd1;
                            if (load_first) begin
                                st       <= ST_DATA;
                                sh       <= head.data;
                                byte_q   <= head.data;
                                cur_last <= head.last;
                                crc      <= CRC_INIT;
                                ones     <= '0;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (stuff_now) begin
                            line <= 1'b0;
                            ones <= '0;
                        end else begin
                            line <= cur_bit;
                            ones <= ones_nx;
                            crc  <= crc_nx;
                            sh   <= {1'b0, sh[7:1]};
                            idx  <= idx + 3'd1;
                            if (byte_end) begin
                                rx_v <= 1'b1;
                                rx_d <= byte_q;
                                rx_l <= cur_last;
                                if (cur_last) begin
                                    st         <= ST_FCS;
                                    sh         <= ~crc_nx[7:0];
                                    fcs2       <= ~crc_nx[15:8];
                                    fcs_second <= 1'b0;
                                end else if (!empty) begin
                                    sh       <= head.data;
                                    byte_q   <= head.data;
                                    cur_last <= head.last;
                                end else begin
                                    st      <= ST_ABORT;
                                    und_p   <= 1'b1;
                                    discard <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_FCS: begin
                        if (stuff_now) begin
                            line <= 1'b0;
                            ones <= '0;
                        end else begin
                            line <= cur_bit;
                            ones <= ones_nx;
                            sh   <= {1'b0, sh[7:1]};
                            idx  <= idx + 3'd1;
                            if (byte_end) begin
                                if (!fcs_second) begin
                                    sh         <= fcs2;
                                    fcs_second <= 1'b1;
                                end else begin
                                    st     <= ST_FLAG;
                                    done_p <= 1'b1;
                                    pend   <= (ones_nx == 3'd5);
                                end
                            end
                        end
                    end
                    default: begin
                        line <= 1'b1;
                        idx  <= idx + 3'd1;
                        if (byte_end) st <= ST_FLAG;
                    end
                endcase
            end
        end
    end

    AST_STUFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA || st == ST_FCS) |-> (ones <= 3'd5)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_p |=> !done_p); // R6
    AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> (st != ST_DATA)); // R7
endmodule

// File: rtl/htx_irq.sv
// Module htx_irq: sticky interrupt status bits with write-one-to-clear.
// Assumes set sources are single-cycle or level events and set wins over clear.
module htx_irq #(
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set,
    input  logic [NB-1:0] clr,
    output logic [NB-1:0] status
);
    // Hold, clear and set of every status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R12
endmodule

// File: rtl/htx_fifo_ctrl.sv
// Module htx_fifo_ctrl: per-channel HDLC transmit FIFO controller top.
// Ties the byte FIFO, the bit engine and the interrupt bits together.
// Assumes the host never writes faster than one byte per cycle.
module htx_fifo_ctrl
    import htx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    wr_func,
    output logic [CW-1:0] free_cnt,
    input  logic [CW-1:0] thresh,
    input  logic [2:0]    irq_clr,
    output logic [2:0]    irq_status,
    input  logic          bit_tick,
    input  logic          loop_en,
    output logic          tx_bit,
    output logic          rx_wr_en,
    output logic [7:0]    rx_data,
    output logic          rx_last
);
    fifo_ent_t     wr_ent, head;
    logic          empty, pop, line, done_p, und_p, rx_v, rx_l_i;
    logic [7:0]    rx_d;
    logic [CW-1:0] level;
    logic [2:0]    irq_set;

    // Host entry, free space, interrupt sources and loopback routing.
    always_comb begin
        wr_ent.data = wr_data;
        wr_ent.last = (wr_func == FUNC_LAST);
        free_cnt    = CW'(DEPTH) - level;
        irq_set     = {und_p, done_p, (level < thresh)};
        tx_bit      = loop_en ? 1'b1 : line;
        rx_wr_en    = rx_v && loop_en;
        rx_data     = rx_d;
        rx_last     = rx_l_i;
    end

    htx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_ent(wr_ent),
        .pop(pop), .head(head), .empty(empty), .level(level)
    );

    htx_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_tick), .head(head), .empty(empty),
        .pop(pop), .line(line), .done_p(done_p), .und_p(und_p),
        .rx_v(rx_v), .rx_d(rx_d), .rx_l(rx_l_i)
    );

    htx_irq #(.NB(3)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .status(irq_status)
    );
endmodule

// File: tb/htx_fifo_ctrl_bench.sv
// Bench for htx_fifo_ctrl: table-driven frames, then directed corner cases.
// A bit-level decoder rebuilds frames from tx_bit.
module htx_fifo_ctrl_bench;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);
    // {data func code, length, first byte, byte step}
    localparam logic [25:0] VECS [0:3] = '{
        {2'b00, 8'd3, 8'hFF, 8'h00},
        {2'b10, 8'd5, 8'h7E, 8'h00},
        {2'b11, 8'd1, 8'h00, 8'h01},
        {2'b00, 8'd8, 8'h10, 8'h11}
    };

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, bit_tick = 1'b1, loop_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_func = '0;
    logic [CW-1:0] thresh = CW'(4), free_cnt;
    logic [2:0] irq_clr = '0, irq_status;
    logic tx_bit, rx_wr_en, rx_last;
    logic [7:0] rx_data;

    int checks = 0, errors = 0, cyc = 0;
    int frames = 0, aborts = 0, bad_frames = 0, ones_d = 0, bitcnt = 0, got_len = 0;
    bit got_crc_ok = 0;
    logic raw [0:1023];
    logic [7:0] got [0:127];
    logic en_q = 1'b0, loop_q = 1'b0;
    int rx_n = 0, rx_stray = 0, loop_zero = 0;
    logic [7:0] rx_got [0:15];
    logic rx_lst [0:15];

    htx_fifo_ctrl #(.DEPTH(DEPTH)) u_htx_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_func(wr_func),
        .free_cnt(free_cnt), .thresh(thresh), .irq_clr(irq_clr), .irq_status(irq_status),
        .bit_tick(bit_tick), .loop_en(loop_en), .tx_bit(tx_bit), .rx_wr_en(rx_wr_en),
        .rx_data(rx_data), .rx_last(rx_last)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        en_q   <= bit_tick && !loop_en && rst_n;
        loop_q <= loop_en;
        cyc    <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Line decoder: drop inserted zeros, find flags and aborts, check FCS.
    always @(negedge clk) begin
        if (!rst_n) begin
            ones_d = 0; bitcnt = 0;
        end else if (en_q) begin
            if (ones_d == 5 && tx_bit == 1'b0) begin
                ones_d = 0;
            end else if (tx_bit == 1'b1) begin
                ones_d = ones_d + 1;
                if (ones_d >= 7) begin
                    if (ones_d == 7) aborts = aborts + 1;
                    bitcnt = 0;
                end else begin
                    if (bitcnt < 1024) raw[bitcnt] = 1'b1;
                    bitcnt = bitcnt + 1;
                end
            end else begin
                if (ones_d == 6) begin
                    int nb;
                    nb = bitcnt - 7;
                    if (nb >= 24 && nb % 8 == 0 && nb <= 1016) begin
                        logic [15:0] c;
                        c = 16'hFFFF;
                        for (int i = 0; i < nb; i++) begin
                            logic fb;
                            fb = c[0] ^ raw[i];
                            c = {1'b0, c[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
                            got[i/8][i%8] = raw[i];
                        end
                        got_crc_ok = (c == 16'hF0B8);
                        got_len = nb / 8 - 2;
                        frames = frames + 1;
                    end else if (nb > 0) begin
                        bad_frames = bad_frames + 1;
                    end
                    bitcnt = 0;
                end else begin
                    if (bitcnt < 1024) raw[bitcnt] = 1'b0;
                    bitcnt = bitcnt + 1;
                end
                ones_d = 0;
            end
        end
    end

    // Loopback monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_wr_en && !loop_q) rx_stray = rx_stray + 1;
            if (rx_wr_en && rx_n < 16) begin
                rx_got[rx_n] = rx_data;
                rx_lst[rx_n] = rx_last;
                rx_n = rx_n + 1;
            end
            if (loop_q && tx_bit == 1'b0) loop_zero = loop_zero + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic [1:0] f);
        wr_en = 1'b1; wr_data = d; wr_func = f;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input int len, input logic [7:0] seed, input logic [7:0] step,
                        input logic [1:0] f);
        for (int i = 0; i < len; i++)
            put(seed + 8'(i) * step, (i == len - 1) ? 2'b01 : f);
    endtask

    task automatic clr_irq(input logic [2:0] m);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    task automatic wait_frame(input int target);
        for (int i = 0; i < 4000 && frames < target; i++) @(negedge clk);
    endtask

    task automatic check_frame(input int target, input int len, input logic [7:0] seed,
                               input logic [7:0] step, input string req);
        int mism;
        wait_frame(target);
        chk(frames >= target, {req, " frame seen"}, frames, target);
        chk(got_len == len, {req, " length"}, got_len, len);
        chk(got_crc_ok, {req, " FCS"}, int'(got_crc_ok), 1);
        mism = 0;
        for (int i = 0; i < len && i < 128; i++)
            if (got[i] !== seed + 8'(i) * step) mism = mism + 1;
        chk(mism == 0, {req, " payload"}, mism, 0);
    endtask

    initial begin
        int f0, a0;
        logic [15:0] w;
        bit rot_ok;
        repeat (4) @(negedge clk);
        chk(free_cnt == CW'(DEPTH), "R11 free count in reset", free_cnt, DEPTH);
        chk(irq_status == 3'b000, "R11 status in reset", irq_status, 0);
        chk(tx_bit == 1'b1 && rx_wr_en == 1'b0, "R11 line and rx in reset", tx_bit, 1);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // R8: sixteen idle line bits, periodic in eight and a rotation of 0x7E.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            w[i] = tx_bit;
        end
        rot_ok = 1'b0;
        for (int r = 0; r < 8; r++) begin
            logic [7:0] v;
            for (int j = 0; j < 8; j++) v[j] = w[(j + r) % 8];
            if (v == 8'h7E && w[7:0] == w[15:8]) rot_ok = 1'b1;
        end
        chk(rot_ok, "R8 idle flag pattern", w, 16'h7E7E);
        chk(frames == 0 && aborts == 0 && bad_frames == 0, "R8 nothing decoded when idle",
            frames + aborts + bad_frames, 0);
        chk(irq_status[0] == 1'b1, "R5 below threshold when empty", irq_status[0], 1);

        // Table walk: R1 function codes and R9 line format, R6 and R12 on done bit.
        for (int k = 0; k < 4; k++) begin
            clr_irq(3'b010);
            chk(irq_status[1] == 1'b0, "R12 done bit cleared", irq_status[1], 0);
            f0 = frames;
            send(int'(VECS[k][23:16]), VECS[k][15:8], VECS[k][7:0], VECS[k][25:24]);
            check_frame(f0 + 1, int'(VECS[k][23:16]), VECS[k][15:8], VECS[k][7:0], "R1 R9 table");
            chk(irq_status[1] == 1'b1, "R6 done after frame", irq_status[1], 1);
        end
        chk(bad_frames == 0, "R9 no malformed frames", bad_frames, 0);

        // R2: two frames queued while the line is paused.
        repeat (30) @(negedge clk);
        bit_tick = 1'b0;
        repeat (2) @(negedge clk);
        f0 = frames;
        send(3, 8'h40, 8'h01, 2'b00);
        send(2, 8'h80, 8'h03, 2'b00);
        chk(free_cnt == CW'(DEPTH - 5), "R3 free count after five writes", free_cnt, DEPTH - 5);
        bit_tick = 1'b1;
        check_frame(f0 + 1, 3, 8'h40, 8'h01, "R2 first queued");
        check_frame(f0 + 2, 2, 8'h80, 8'h03, "R2 second queued");

        // R4: overflow drops a byte silently; R5 threshold clear rule.
        repeat (30) @(negedge clk);
        bit_tick = 1'b0;
        repeat (2) @(negedge clk);
        clr_irq(3'b111);
        f0 = frames;
        send(16, 8'hA0, 8'h05, 2'b00);
        chk(free_cnt == '0, "R3 free count when full", free_cnt, 0);
        put(8'h55, 2'b01);
        chk(free_cnt == '0, "R4 write when full ignored", free_cnt, 0);
        chk(irq_status[2:1] == 2'b00, "R4 no interrupt on overflow", irq_status[2:1], 0);
        clr_irq(3'b001);
        chk(irq_status[0] == 1'b0, "R5 clears at or above threshold", irq_status[0], 0);
        bit_tick = 1'b1;
        check_frame(f0 + 1, 16, 8'hA0, 8'h05, "R4 frame without dropped byte");
        repeat (200) @(negedge clk);
        chk(frames == f0 + 1, "R4 dropped byte sends nothing", frames, f0 + 1);
        chk(free_cnt == CW'(DEPTH), "R3 free count after drain", free_cnt, DEPTH);
        chk(irq_status[0] == 1'b1, "R5 set after drain", irq_status[0], 1);

        // R7: underrun, abort, discard of the remainder, recovery.
        clr_irq(3'b110);
        f0 = frames;
        a0 = aborts;
        put(8'h3C, 2'b00);
        put(8'hC3, 2'b10);
        repeat (120) @(negedge clk);
        chk(irq_status[2] == 1'b1, "R7 underrun bit", irq_status[2], 1);
        chk(aborts > a0, "R7 abort on line", aborts - a0, 1);
        chk(frames == f0, "R7 no frame for aborted data", frames, f0);
        chk(irq_status[1] == 1'b0, "R7 no done for aborted frame", irq_status[1], 0);
        put(8'h99, 2'b01);
        repeat (3) @(negedge clk);
        chk(free_cnt == CW'(DEPTH), "R7 remainder discarded", free_cnt, DEPTH);
        repeat (100) @(negedge clk);
        chk(frames == f0, "R7 discarded byte not sent", frames, f0);
        send(2, 8'h5A, 8'h4B, 2'b00);
        check_frame(f0 + 1, 2, 8'h5A, 8'h4B, "R7 recovery frame");

        // R10: loopback delivers bytes to the receive port.
        repeat (40) @(negedge clk);
        chk(rx_stray == 0, "R10 no rx writes outside loopback", rx_stray, 0);
        #2 loop_en = 1'b1;
        repeat (20) @(negedge clk);
        rx_n = 0;
        send(3, 8'h21, 8'h13, 2'b00);
        repeat (200) @(negedge clk);
        chk(rx_n == 3, "R10 loopback byte count", rx_n, 3);
        begin
            int mism;
            mism = 0;
            for (int i = 0; i < 3; i++) begin
                if (rx_got[i] !== 8'h21 + 8'(i) * 8'h13) mism = mism + 1;
                if (rx_lst[i] !== (i == 2)) mism = mism + 1;
            end
            chk(mism == 0, "R10 loopback data and last flag", mism, 0);
        end
        chk(loop_zero == 0, "R10 line held high in loopback", loop_zero, 0);
        #2 loop_en = 1'b0;
        repeat (20) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule